// File: doc/BRIEF.md
# Dual-Direction Mailbox with Doorbells

This register block lets a host processor and a service engine pass fixed-size packets to each other. Each party has its own register port, with an address, a write enable and 64-bit data. The host fills four command words and then raises a bit in the engine-facing doorbell. The engine fills four response words and then raises bits in the host-facing doorbell. Each doorbell drives an interrupt line toward its owner. The line stays high for as long as that doorbell holds any set bit.

Every doorbell is reachable through three addresses. A plain write replaces the value. A clear-style write ANDs the data into the doorbell. A set-style write ORs the data into the doorbell. The party that owns a doorbell acknowledges events by clearing bits. The other party raises events by setting bits. When both act on the same doorbell in one cycle, the set is applied first and the clear second, so the two actions on different bits both take effect.

Bits are numbered from the most significant end, so bit n lives at vector position 63-n. The host-facing doorbell implements only a fixed set of event bits. Its other bits are held at zero.

Top module: `dual_mailbox`

## Requirements
- R1: After a synchronous active-low reset, all eight data registers and both doorbells read as zero, and both interrupt lines are low.
- R2: The address map is as follows. Command words 0..3 are at 0x50..0x53 and response words 0..3 are at 0x54..0x57. The engine doorbell is at 0x60 (replace), 0x61 (AND) and 0x62 (OR). The host doorbell is at 0x63 (replace), 0x64 (AND) and 0x65 (OR). A read request produces rvalid and the data exactly one cycle later. All three addresses of a doorbell read its value, and unmapped addresses read zero. A write request never produces rvalid.
- R3: Only the host port writes the command words. Engine writes to 0x50..0x53 leave them unchanged.
- R4: Only the engine port writes the response words. Host writes to 0x54..0x57 leave them unchanged.
- R5: The non-owning port can change a doorbell through its three addresses. A write to the replace address loads the data. A write to the AND address loads doorbell AND data. A write to the OR address loads doorbell OR data.
- R6: The owning port can change its own doorbell only through the AND address. Its writes to the replace and OR addresses are ignored. The host owns the host doorbell and the engine owns the engine doorbell.
- R7: Only certain host doorbell bits are implemented, namely MSB-numbered bits 0 (response ready), 1 (command taken), 2 (deep-stop exit), 3 (engine back from reset), 4 (passthrough) and 14 (timer). This gives the mask 0xF802_0000_0000_0000. All other bits read zero whatever is written. All 64 bits of the engine doorbell are implemented, and its bit 0 means a command is waiting.
- R8: Each interrupt line is a registered "doorbell non-zero" flag. It rises one clock edge after the edge that made the doorbell non-zero, and it falls one edge after the edge that cleared the doorbell to zero.
- R9: When the non-owner and the owner write the same doorbell in one cycle, the non-owner's update is applied first and the owner's AND is applied to that result.
- R10: Both ports may read any register, including in the same cycle. A read that coincides with a write to the same register returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_req | input | 1 | Host port access request |
| host_we | input | 1 | Host access is a write |
| host_addr | input | ADDR_W | Host register address |
| host_wdata | input | DATA_W | Host write data |
| host_rvalid | output | 1 | Host read data valid |
| host_rdata | output | DATA_W | Host read data |
| eng_req | input | 1 | Engine port access request |
| eng_we | input | 1 | Engine access is a write |
| eng_addr | input | ADDR_W | Engine register address |
| eng_wdata | input | DATA_W | Engine write data |
| eng_rvalid | output | 1 | Engine read data valid |
| eng_rdata | output | DATA_W | Engine read data |
| host_irq | output | 1 | Interrupt toward host, high while the host doorbell is non-zero |
| eng_irq | output | 1 | Interrupt toward engine, high while the engine doorbell is non-zero |

## Verification
The properties assume two things about the ports. First, a request is a single-cycle pulse, so every read is one cycle that is followed by its own rvalid. Second, properties about a register being left unchanged or cleared exclude cycles in which the permitted port writes that same register. The stimulus drives each request for exactly one clock and releases it just after the edge. It creates same-cycle overlaps only in the dedicated collision and read-during-write cases, and there the expected values follow R9 and R10.

// File: rtl/mbx_pkg.sv
// Package: shared types for the dual-direction mailbox.
// Assumes: register region and doorbell alias are decoded once per port.
package mbx_pkg;

    // Which storage an address falls into.
    typedef enum logic [2:0] {
        RGN_NONE,
        RGN_CMD,
        RGN_RSP,
        RGN_EBELL,
        RGN_HBELL
    } region_e;

    // How a doorbell write is combined with the current value.
    typedef enum logic [1:0] {
        ACC_RW,
        ACC_AND,
        ACC_OR
    } alias_e;

    // Offset within a three-address doorbell group -> combining mode.
    function automatic alias_e alias_of(input int unsigned off);
        case (off)
            0:       return ACC_RW;
            1:       return ACC_AND;
            default: return ACC_OR;
        endcase
    endfunction

endpackage

// File: rtl/mbx_decode.sv
// Module: mbx_decode
// Turns one port's address into a region, a word index and a doorbell alias.
// Assumes: the data windows and doorbell groups do not overlap.
module mbx_decode
    import mbx_pkg::*;
#(
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned NREG       = 4,
    parameter int unsigned IDX_W      = 2,
    parameter int unsigned CMD_BASE   = 'h50,
    parameter int unsigned RSP_BASE   = 'h54,
    parameter int unsigned EBELL_BASE = 'h60,
    parameter int unsigned HBELL_BASE = 'h63
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [IDX_W-1:0]  idx,
    output alias_e            acc
);

    localparam int unsigned BELL_SPAN = 3;

    int unsigned a;

    // Compare the address against each window and pick out index / alias.
    always_comb begin
        a      = 32'(addr);
        region = RGN_NONE;
        idx    = '0;
        acc    = ACC_RW;
        if (a >= CMD_BASE && a < CMD_BASE + NREG) begin
            region = RGN_CMD;
            idx    = IDX_W'(a - CMD_BASE);
        end else if (a >= RSP_BASE && a < RSP_BASE + NREG) begin
            region = RGN_RSP;
            idx    = IDX_W'(a - RSP_BASE);
        end else if (a >= EBELL_BASE && a < EBELL_BASE + BELL_SPAN) begin
            region = RGN_EBELL;
            acc    = alias_of(a - EBELL_BASE);
        end else if (a >= HBELL_BASE && a < HBELL_BASE + BELL_SPAN) begin
            region = RGN_HBELL;
            acc    = alias_of(a - HBELL_BASE);
        end
    end

endmodule

// File: rtl/mbx_data_bank.sv
// Module: mbx_data_bank
// A bank of NREG data words written by exactly one port.
// Assumes: wr_idx is valid whenever wr_en is high.
module mbx_data_bank #(
    parameter int unsigned NREG   = 4,
    parameter int unsigned DATA_W = 64,
    parameter int unsigned IDX_W  = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_idx,
    input  logic [DATA_W-1:0]            wr_data,
    output logic [NREG-1:0][DATA_W-1:0]  words_q
);

    logic [NREG-1:0] hit;

    // One write strobe per word.
    for (genvar g = 0; g < NREG; g++) begin : g_hit
        assign hit[g] = wr_en && (wr_idx == IDX_W'(g));
    end

    // Word storage, cleared at reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            words_q <= '0;
        end else begin
            for (int i = 0; i < NREG; i++) begin
                if (hit[i]) words_q[i] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/mbx_doorbell.sv
// Module: mbx_doorbell
// One doorbell: the peer may replace/AND/OR it, the owner may only AND it.
// The peer update is merged first, the owner's AND second, then the mask of
// implemented bits. The interrupt is a registered non-zero flag.
// Assumes: peer_acc is meaningful only while peer_wr is high.
module mbx_doorbell
    import mbx_pkg::*;
#(
    parameter int unsigned       DATA_W    = 64,
    parameter logic [DATA_W-1:0] IMPL_MASK = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              peer_wr,
    input  alias_e            peer_acc,
    input  logic [DATA_W-1:0] peer_data,
    input  logic              owner_clr,
    input  logic [DATA_W-1:0] owner_data,
    output logic [DATA_W-1:0] bell_q,
    output logic              irq_q
);

    logic [DATA_W-1:0] after_peer;
    logic [DATA_W-1:0] bell_d;

    // Apply the peer's write according to its alias.
    always_comb begin
        after_peer = bell_q;
        if (peer_wr) begin
            case (peer_acc)
                ACC_RW:  after_peer = peer_data;
                ACC_AND: after_peer = bell_q & peer_data;
                ACC_OR:  after_peer = bell_q | peer_data;
                default: after_peer = bell_q;
            endcase
        end
    end

    // Owner acknowledge on top of the peer result, then keep implemented bits.
    always_comb begin
        bell_d = after_peer;
        if (owner_clr) bell_d = bell_d & owner_data;
        bell_d = bell_d & IMPL_MASK;
    end

    // Doorbell storage and the registered interrupt flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bell_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            bell_q <= bell_d;
            irq_q  <= |bell_q;
        end
    end

endmodule

// File: rtl/dual_mailbox.sv
// Module: dual_mailbox (top)
// Two register ports (host, engine) over command words, response words and
// two doorbells. Reads from either port return data one cycle later.
// Assumes: each request lasts one cycle; unmapped accesses are harmless.
module dual_mailbox
    import mbx_pkg::*;
#(
    parameter int unsigned       ADDR_W     = 8,
    parameter int unsigned       DATA_W     = 64,
    parameter int unsigned       NREG       = 4,
    parameter int unsigned       CMD_BASE   = 'h50,
    parameter int unsigned       RSP_BASE   = 'h54,
    parameter int unsigned       EBELL_BASE = 'h60,
    parameter int unsigned       HBELL_BASE = 'h63,
    parameter logic [DATA_W-1:0] HBELL_IMPL = 64'hF802_0000_0000_0000,
    parameter logic [DATA_W-1:0] EBELL_IMPL = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_rvalid,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              eng_req,
    input  logic              eng_we,
    input  logic [ADDR_W-1:0] eng_addr,
    input  logic [DATA_W-1:0] eng_wdata,
    output logic              eng_rvalid,
    output logic [DATA_W-1:0] eng_rdata,
    output logic              host_irq,
    output logic              eng_irq
);

    localparam int unsigned IDX_W  = (NREG > 1) ? $clog2(NREG) : 1;
    localparam int unsigned NPORT  = 2;
    localparam int unsigned P_HOST = 0;
    localparam int unsigned P_ENG  = 1;

    logic [NREG-1:0][DATA_W-1:0] cmd_q;
    logic [NREG-1:0][DATA_W-1:0] rsp_q;
    logic [DATA_W-1:0]           ebell_q;
    logic [DATA_W-1:0]           hbell_q;

    logic              p_req  [NPORT];
    logic              p_we   [NPORT];
    logic [ADDR_W-1:0] p_addr [NPORT];

    assign p_req[P_HOST]  = host_req;
    assign p_we[P_HOST]   = host_we;
    assign p_addr[P_HOST] = host_addr;
    assign p_req[P_ENG]   = eng_req;
    assign p_we[P_ENG]    = eng_we;
    assign p_addr[P_ENG]  = eng_addr;

    // Per-port decode and registered read path.
    for (genvar p = 0; p < NPORT; p++) begin : g_port
        region_e           rgn;
        logic [IDX_W-1:0]  idx;
        alias_e            acc;
        logic              rvalid_q;
        logic [DATA_W-1:0] rdata_q;
        logic [DATA_W-1:0] rmux;

        mbx_decode #(
            .ADDR_W     (ADDR_W),
            .NREG       (NREG),
            .IDX_W      (IDX_W),
            .CMD_BASE   (CMD_BASE),
            .RSP_BASE   (RSP_BASE),
            .EBELL_BASE (EBELL_BASE),
            .HBELL_BASE (HBELL_BASE)
        ) dec_i (
            .addr   (p_addr[p]),
            .region (rgn),
            .idx    (idx),
            .acc    (acc)
        );

        // Select the word this port is reading.
        always_comb begin
            case (rgn)
                RGN_CMD:   rmux = cmd_q[idx];
                RGN_RSP:   rmux = rsp_q[idx];
                RGN_EBELL: rmux = ebell_q;
                RGN_HBELL: rmux = hbell_q;
                default:   rmux = '0;
            endcase
        end

        // Capture read data one cycle after the request.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rvalid_q <= 1'b0;
                rdata_q  <= '0;
            end else begin
                rvalid_q <= p_req[p] && !p_we[p];
                if (p_req[p] && !p_we[p]) rdata_q <= rmux;
            end
        end
    end

    assign host_rvalid = g_port[P_HOST].rvalid_q;
    assign host_rdata  = g_port[P_HOST].rdata_q;
    assign eng_rvalid  = g_port[P_ENG].rvalid_q;
    assign eng_rdata   = g_port[P_ENG].rdata_q;

    logic h_wr, e_wr;
    assign h_wr = host_req && host_we;
    assign e_wr = eng_req && eng_we;

    // Command words: host writes only.
    mbx_data_bank #(.NREG(NREG), .DATA_W(DATA_W), .IDX_W(IDX_W)) cmd_bank_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (h_wr && g_port[P_HOST].rgn == RGN_CMD),
        .wr_idx  (g_port[P_HOST].idx),
        .wr_data (host_wdata),
        .words_q (cmd_q)
    );

    // Response words: engine writes only.
    mbx_data_bank #(.NREG(NREG), .DATA_W(DATA_W), .IDX_W(IDX_W)) rsp_bank_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (e_wr && g_port[P_ENG].rgn == RGN_RSP),
        .wr_idx  (g_port[P_ENG].idx),
        .wr_data (eng_wdata),
        .words_q (rsp_q)
    );

    // Engine doorbell: host raises, engine acknowledges.
    mbx_doorbell #(.DATA_W(DATA_W), .IMPL_MASK(EBELL_IMPL)) ebell_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .peer_wr    (h_wr && g_port[P_HOST].rgn == RGN_EBELL),
        .peer_acc   (g_port[P_HOST].acc),
        .peer_data  (host_wdata),
        .owner_clr  (e_wr && g_port[P_ENG].rgn == RGN_EBELL
                     && g_port[P_ENG].acc == ACC_AND),
        .owner_data (eng_wdata),
        .bell_q     (ebell_q),
        .irq_q      (eng_irq)
    );

    // Host doorbell: engine raises, host acknowledges.
    mbx_doorbell #(.DATA_W(DATA_W), .IMPL_MASK(HBELL_IMPL)) hbell_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .peer_wr    (e_wr && g_port[P_ENG].rgn == RGN_HBELL),
        .peer_acc   (g_port[P_ENG].acc),
        .peer_data  (eng_wdata),
        .owner_clr  (h_wr && g_port[P_HOST].rgn == RGN_HBELL
                     && g_port[P_HOST].acc == ACC_AND),
        .owner_data (host_wdata),
        .bell_q     (hbell_q),
        .irq_q      (host_irq)
    );

endmodule

// File: rtl/mbx_checker.sv
// Module: mbx_checker
// Temporal properties of dual_mailbox, attached through bind.
// Assumes: requests are single-cycle pulses.
module mbx_checker #(
    parameter int unsigned       ADDR_W     = 8,
    parameter int unsigned       DATA_W     = 64,
    parameter int unsigned       NREG       = 4,
    parameter int unsigned       CMD_BASE   = 'h50,
    parameter int unsigned       RSP_BASE   = 'h54,
    parameter int unsigned       HBELL_BASE = 'h63,
    parameter logic [DATA_W-1:0] HBELL_IMPL = 64'hF802_0000_0000_0000
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        host_req,
    input logic                        host_we,
    input logic [ADDR_W-1:0]           host_addr,
    input logic [DATA_W-1:0]           host_wdata,
    input logic                        host_rvalid,
    input logic [DATA_W-1:0]           host_rdata,
    input logic                        eng_req,
    input logic                        eng_we,
    input logic [ADDR_W-1:0]           eng_addr,
    input logic [DATA_W-1:0]           eng_wdata,
    input logic                        host_irq,
    input logic [NREG-1:0][DATA_W-1:0] cmd_q,
    input logic [NREG-1:0][DATA_W-1:0] rsp_q,
    input logic [DATA_W-1:0]           hbell_q
);

    function automatic logic in_win(input logic [ADDR_W-1:0] a,
                                    input int unsigned base, input int unsigned n);
        return (32'(a) >= base) && (32'(a) < base + n);
    endfunction

    logic h_wr, e_wr, h_rd;
    logic h_cmd, e_cmd, h_rsp, e_rsp, h_hb, e_hb;
    assign h_wr  = host_req && host_we;
    assign e_wr  = eng_req && eng_we;
    assign h_rd  = host_req && !host_we;
    assign h_cmd = in_win(host_addr, CMD_BASE, NREG);
    assign e_cmd = in_win(eng_addr, CMD_BASE, NREG);
    assign h_rsp = in_win(host_addr, RSP_BASE, NREG);
    assign e_rsp = in_win(eng_addr, RSP_BASE, NREG);
    assign h_hb  = in_win(host_addr, HBELL_BASE, 3);
    assign e_hb  = in_win(eng_addr, HBELL_BASE, 3);

    AST_READ_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        h_rd |=> host_rvalid); // R2
    AST_WRITE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        h_wr |=> !host_rvalid); // R2
    AST_CMD_ENGINE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (e_wr && e_cmd && !h_wr) |=> $stable(cmd_q)); // R3
    AST_RSP_HOST_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (h_wr && h_rsp && !e_wr) |=> $stable(rsp_q)); // R4
    AST_HBELL_OWNER_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (h_wr && h_hb && 32'(host_addr) != HBELL_BASE + 1 && !(e_wr && e_hb))
        |=> $stable(hbell_q)); // R6
    AST_HBELL_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (h_rd && h_hb) |=> ((host_rdata & ~HBELL_IMPL) == '0)); // R7
    AST_HIRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (h_wr && 32'(host_addr) == HBELL_BASE + 1 && host_wdata == '0
         && !(e_wr && e_hb)) |=> ##1 !host_irq); // R8
    AST_HBELL_MERGE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (e_wr && 32'(eng_addr) == HBELL_BASE + 2
         && h_wr && 32'(host_addr) == HBELL_BASE + 1)
        |=> hbell_q == (($past(hbell_q) | $past(eng_wdata))
                        & $past(host_wdata) & HBELL_IMPL)); // R9

endmodule

bind dual_mailbox mbx_checker #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .NREG       (NREG),
    .CMD_BASE   (CMD_BASE),
    .RSP_BASE   (RSP_BASE),
    .HBELL_BASE (HBELL_BASE),
    .HBELL_IMPL (HBELL_IMPL)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_req    (host_req),
    .host_we     (host_we),
    .host_addr   (host_addr),
    .host_wdata  (host_wdata),
    .host_rvalid (host_rvalid),
    .host_rdata  (host_rdata),
    .eng_req     (eng_req),
    .eng_we      (eng_we),
    .eng_addr    (eng_addr),
    .eng_wdata   (eng_wdata),
    .host_irq    (host_irq),
    .cmd_q       (cmd_q),
    .rsp_q       (rsp_q),
    .hbell_q     (hbell_q)
);

// File: tb/dual_mailbox_tb_top.sv
// Scoreboard bench: driver tasks queue expected read data, a monitor compares
// each returned word as rvalid appears on either port.
module dual_mailbox_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam logic [63:0] HMASK = 64'hF802_0000_0000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0, host_we = 1'b0;
    logic [7:0]  host_addr = '0;
    logic [63:0] host_wdata = '0;
    logic        host_rvalid;
    logic [63:0] host_rdata;
    logic        eng_req = 1'b0, eng_we = 1'b0;
    logic [7:0]  eng_addr = '0;
    logic [63:0] eng_wdata = '0;
    logic        eng_rvalid;
    logic [63:0] eng_rdata;
    logic        host_irq, eng_irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [63:0] hq_val[$];
    string       hq_tag[$];
    logic [63:0] eq_val[$];
    string       eq_tag[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_mailbox dut_i (
        .clk(clk), .rst_n(rst_n),
        .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rvalid(host_rvalid), .host_rdata(host_rdata),
        .eng_req(eng_req), .eng_we(eng_we), .eng_addr(eng_addr),
        .eng_wdata(eng_wdata), .eng_rvalid(eng_rvalid), .eng_rdata(eng_rdata),
        .host_irq(host_irq), .eng_irq(eng_irq)
    );

    task automatic check(input logic [63:0] act, input logic [63:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: compare returned read data against the scoreboard queues.
    always @(negedge clk) begin
        if (rst_n && host_rvalid) begin
            if (hq_val.size() == 0) check(host_rdata, 64'hX, "R2 host unexpected rvalid");
            else check(host_rdata, hq_val.pop_front(), hq_tag.pop_front());
        end
        if (rst_n && eng_rvalid) begin
            if (eq_val.size() == 0) check(eng_rdata, 64'hX, "R2 engine unexpected rvalid");
            else check(eng_rdata, eq_val.pop_front(), eq_tag.pop_front());
        end
    end

    // Drive both ports for one clock, released just after the edge.
    task automatic cyc(input logic hv, input logic hw, input logic [7:0] ha, input logic [63:0] hd,
                       input logic ev, input logic ew, input logic [7:0] ea, input logic [63:0] ed);
        @(negedge clk);
        host_req = hv; host_we = hw; host_addr = ha; host_wdata = hd;
        eng_req = ev;  eng_we = ew;  eng_addr = ea;  eng_wdata = ed;
        @(posedge clk);
        #1;
        host_req = 1'b0; host_we = 1'b0;
        eng_req = 1'b0;  eng_we = 1'b0;
    endtask

    task automatic h_wr(input logic [7:0] a, input logic [63:0] d);
        cyc(1, 1, a, d, 0, 0, 8'h0, 64'h0);
    endtask
    task automatic e_wr(input logic [7:0] a, input logic [63:0] d);
        cyc(0, 0, 8'h0, 64'h0, 1, 1, a, d);
    endtask
    task automatic h_rd(input logic [7:0] a, input logic [63:0] exp, input string tag);
        hq_val.push_back(exp); hq_tag.push_back(tag);
        cyc(1, 0, a, 64'h0, 0, 0, 8'h0, 64'h0);
    endtask
    task automatic e_rd(input logic [7:0] a, input logic [63:0] exp, input string tag);
        eq_val.push_back(exp); eq_tag.push_back(tag);
        cyc(0, 0, 8'h0, 64'h0, 1, 0, a, 64'h0);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: everything zero after reset
        @(negedge clk);
        check(64'(host_irq), 64'h0, "R1 host_irq after reset");
        check(64'(eng_irq), 64'h0, "R1 eng_irq after reset");
        for (int a = 'h50; a <= 'h57; a++) h_rd(8'(a), 64'h0, "R1 data word zero");
        for (int a = 'h60; a <= 'h65; a++) h_rd(8'(a), 64'h0, "R1 doorbell zero");

        // R3: host writes command words, engine writes are dropped
        for (int k = 0; k < 4; k++) h_wr(8'('h50 + k), 64'hC0DE_0000_0000_0000 + 64'(k));
        e_wr(8'h52, 64'hDEAD_BEEF_DEAD_BEEF);
        for (int k = 0; k < 4; k++)
            e_rd(8'('h50 + k), 64'hC0DE_0000_0000_0000 + 64'(k), "R3 command word");
        h_rd(8'h52, 64'hC0DE_0000_0000_0002, "R10 host reads command word");

        // R4: engine writes response words, host writes are dropped
        for (int k = 0; k < 4; k++) e_wr(8'('h54 + k), 64'hA5A5_0000_0000_0000 + 64'(k << 4));
        h_wr(8'h55, 64'h1234_5678_9ABC_DEF0);
        for (int k = 0; k < 4; k++)
            h_rd(8'('h54 + k), 64'hA5A5_0000_0000_0000 + 64'(k << 4), "R4 response word");

        // R2: unmapped addresses read zero
        h_rd(8'h58, 64'h0, "R2 unmapped 0x58");
        e_rd(8'h66, 64'h0, "R2 unmapped 0x66");
        h_rd(8'h4F, 64'h0, "R2 unmapped 0x4F");

        // R5/R8: host raises the engine doorbell via replace
        h_wr(8'h60, 64'h8000_0000_0000_1234);
        @(negedge clk); check(64'(eng_irq), 64'h0, "R8 eng_irq not yet");
        @(negedge clk); check(64'(eng_irq), 64'h1, "R8 eng_irq raised");
        e_rd(8'h60, 64'h8000_0000_0000_1234, "R5 replace alias");
        e_rd(8'h61, 64'h8000_0000_0000_1234, "R2 AND address reads bell");
        e_rd(8'h62, 64'h8000_0000_0000_1234, "R2 OR address reads bell");
        h_wr(8'h62, 64'h0000_0000_00FF_0000);
        h_rd(8'h60, 64'h8000_0000_00FF_1234, "R5 OR alias");
        h_wr(8'h61, 64'hFFFF_FFFF_FFFF_0000);
        h_rd(8'h60, 64'h8000_0000_00FF_0000, "R5 AND alias");
        // R6: owner replace / OR ignored
        e_wr(8'h60, 64'h0);
        e_wr(8'h62, 64'h1);
        e_rd(8'h60, 64'h8000_0000_00FF_0000, "R6 owner replace/OR ignored");
        e_wr(8'h61, 64'h0);
        @(negedge clk);
        @(negedge clk); check(64'(eng_irq), 64'h0, "R8 eng_irq dropped");
        e_rd(8'h60, 64'h0, "R6 owner AND clears");

        // R7: host doorbell implemented bits
        e_wr(8'h65, 64'hFFFF_FFFF_FFFF_FFFF);
        @(negedge clk);
        @(negedge clk); check(64'(host_irq), 64'h1, "R8 host_irq raised");
        h_rd(8'h63, HMASK, "R7 implemented mask");
        h_wr(8'h64, 64'h7FFF_FFFF_FFFF_FFFF);
        h_rd(8'h63, 64'h7802_0000_0000_0000, "R6 owner AND clears bit 0");
        e_wr(8'h63, 64'h0800_0000_0000_0001);
        h_rd(8'h64, 64'h0800_0000_0000_0000, "R7 unimplemented bit dropped");
        h_wr(8'h63, 64'h0);
        h_wr(8'h65, 64'h8000_0000_0000_0000);
        h_rd(8'h65, 64'h0800_0000_0000_0000, "R6 host replace/OR on own bell ignored");

        // R9: same-cycle set by engine and clear by host on the host doorbell
        cyc(1, 1, 8'h64, 64'hF7FF_FFFF_FFFF_FFFF, 1, 1, 8'h65, 64'h8000_0000_0000_0000);
        h_rd(8'h63, 64'h8000_0000_0000_0000, "R9 host bell merge order");
        // R9: engine doorbell, host OR with engine AND
        h_wr(8'h60, 64'hF0);
        cyc(1, 1, 8'h62, 64'h0F, 1, 1, 8'h61, 64'h3C);
        e_rd(8'h60, 64'h3C, "R9 engine bell merge order");

        h_wr(8'h64, 64'h0);
        @(negedge clk);
        @(negedge clk); check(64'(host_irq), 64'h0, "R8 host_irq dropped");

        // R10: read during write returns old value, then the new one
        eq_val.push_back(64'hC0DE_0000_0000_0000); eq_tag.push_back("R10 read during write");
        cyc(1, 1, 8'h50, 64'h1111, 1, 0, 8'h50, 64'h0);
        e_rd(8'h50, 64'h1111, "R10 read after write");
        // R10: simultaneous reads from both ports
        hq_val.push_back(64'hA5A5_0000_0000_0030); hq_tag.push_back("R10 dual read host");
        eq_val.push_back(64'hA5A5_0000_0000_0030); eq_tag.push_back("R10 dual read engine");
        cyc(1, 0, 8'h57, 64'h0, 1, 0, 8'h57, 64'h0);

        repeat (4) @(negedge clk);
        check(64'(hq_val.size() + eq_val.size()), 64'h0, "R2 all reads returned");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule